// File: doc/BRIEF.md
# E1 CRC4 Multiframe Alignment Controller

This block sits behind the basic frame aligner of an E1 receiver. It decides whether CRC4 multiframe alignment has been gained. The decision comes from three inputs: a 125 µs frame strobe, a flag saying basic (doubleframe) alignment is valid, and a single-cycle pulse for each multiframe alignment signal that the pattern detector finds. Pattern detection and CRC arithmetic are done upstream and are not part of this block.

Once basic alignment appears, the block opens a search window of 64 frames (8 ms). The first alignment signal found in the window shrinks the window to 48 frames (6 ms), counted from that signal. A second signal whose distance from the first is a whole multiple of 16 frames (2 ms) declares multiframe lock. When the window runs out, a search-timeout interrupt is raised and the window starts again. If automatic resynchronization is enabled, the first timeout after basic alignment also asks the basic aligner to search again.

While basic alignment is absent:
- the block holds the loss-of-multiframe flag high;
- it freezes error and alarm monitoring downstream;
- it asks for an all-ones (AIS) signal toward the system side, unless that request is disabled.

Top module: `e1_mfa_ctrl`

## Requirements
- R1: After reset, `mf_loss_o` is 1 and `mf_regained_o`, `search_tmo_o` and `resync_req_o` are 0.
- R2: In search, a second `mfas_hit_i` whose distance from the first counts a non-zero multiple of 16 frame strobes causes lock. One cycle after that hit, `mf_loss_o` goes to 0, and `mf_regained_o` pulses high for exactly that one cycle.
- R3: A second hit at a distance that is not a multiple of 16 strobes does not lock. It is taken as a new first hit, and a 48-strobe window restarts from it.
- R4: With no hit, `search_tmo_o` pulses for one cycle, in the cycle after the 64th strobe counted from the cycle after `bfa_ok_i` rose. It repeats every 64 strobes while the search goes on.
- R5: A first hit reloads the window to 48 strobes. If no valid second hit follows, `search_tmo_o` pulses after the 48th strobe counted from that hit.
- R6: When `cfg_auto_resync_i` is 1, `resync_req_o` pulses together with the first timeout after basic alignment was gained, and with no later one. When the bit is 0, `resync_req_o` stays 0.
- R7: When `bfa_ok_i` is 0, `mf_loss_o` is 1 in the following cycle and all partial search state is cleared (a hit seen before the loss cannot pair with one after it). Hits received while `bfa_ok_i` is 0 are ignored.
- R8: `ais_req_o` equals `!bfa_ok_i && !cfg_ais_off_i`, and `mon_freeze_o` equals `!bfa_ok_i`; both are combinational.
- R9: If a valid second hit and the strobe that would expire the window arrive in the same cycle, lock wins: `mf_regained_o` pulses and `search_tmo_o` does not.
- R10: Once locked, further hits and strobes leave `mf_loss_o` at 0 and raise no timeout until `bfa_ok_i` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick_i | input | 1 | One-cycle strobe per 125 µs frame |
| bfa_ok_i | input | 1 | Basic frame alignment valid |
| mfas_hit_i | input | 1 | One-cycle pulse per multiframe alignment signal seen |
| cfg_auto_resync_i | input | 1 | Enable basic realignment request on first window expiry |
| cfg_ais_off_i | input | 1 | Suppress the AIS request |
| mf_loss_o | output | 1 | Loss of multiframe alignment |
| mf_regained_o | output | 1 | One-cycle interrupt when multiframe alignment is gained |
| search_tmo_o | output | 1 | One-cycle interrupt on search window expiry |
| resync_req_o | output | 1 | One-cycle request for a new basic alignment search |
| ais_req_o | output | 1 | Request to send AIS toward the system side |
| mon_freeze_o | output | 1 | Freeze error counting and remote alarm detection |

## Verification
Lock and window expiry can fall in the same cycle. This happens when the 48th strobe after a first hit arrives together with a second hit spaced exactly 48 strobes from it. The bench drives the strobe and the hit in one cycle and then compares pulse counters. The recovery count must rise by one, the timeout count must not move, and the loss flag must be low.

// File: rtl/e1_mfa_pkg.sv
package e1_mfa_pkg;

    typedef enum logic [1:0] {
        ST_LOST   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2
    } mfa_state_e;

    typedef struct packed {
        mfa_state_e state;
        logic       mf_loss;
        logic       regained;
        logic       tmo;
        logic       resync;
        logic       first_win;
    } mfa_regs_t;

endpackage

// File: rtl/e1_mfa_window.sv
module e1_mfa_window #(
    parameter int LONG_FRAMES  = 64,
    parameter int SHORT_FRAMES = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic load_long_i,
    input  logic load_short_i,
    input  logic clear_i,
    output logic expire_o
);
    localparam int CW = $clog2(LONG_FRAMES + 1);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_FRAMES);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_FRAMES);

    logic [CW-1:0] cnt_d, cnt_q;

    // Load wins over a strobe in the same cycle.
    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (load_long_i) begin
            cnt_d = LONG_V;
        end else if (load_short_i) begin
            cnt_d = SHORT_V;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    assign expire_o = tick_i && (cnt_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_window_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LONG_V);

endmodule

// File: rtl/e1_mfa_spacing.sv
module e1_mfa_spacing #(
    parameter int LONG_FRAMES = 64,
    parameter int SPAN_FRAMES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    input  logic clear_i,
    output logic pair_ok_o
);
    localparam int SW = $clog2(LONG_FRAMES + 2) + 1;
    localparam logic [SW-1:0] SAT_V  = SW'(LONG_FRAMES);
    localparam logic [SW-1:0] SPAN_V = SW'(SPAN_FRAMES);

    logic [SW-1:0] since_d, since_q, since_eff;
    logic          armed_d, armed_q;

    // Distance includes a strobe arriving in the same cycle as the hit.
    assign since_eff = since_q + SW'(tick_i);

    always_comb begin
        since_d = since_q;
        armed_d = armed_q;
        if (clear_i) begin
            since_d = '0;
            armed_d = 1'b0;
        end else if (restart_i) begin
            since_d = '0;
            armed_d = 1'b1;
        end else if (armed_q && tick_i && (since_q < SAT_V)) begin
            since_d = since_q + 1'b1;
        end
    end

    assign pair_ok_o = armed_q && (since_eff != '0) && ((since_eff % SPAN_V) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            armed_q <= 1'b0;
        end else begin
            since_q <= since_d;
            armed_q <= armed_d;
        end
    end

    assert_no_restart_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(restart_i && clear_i));

endmodule

// File: rtl/e1_mfa_ctrl.sv
module e1_mfa_ctrl
    import e1_mfa_pkg::*;
#(
    parameter int LONG_FRAMES  = 64,
    parameter int SHORT_FRAMES = 48,
    parameter int SPAN_FRAMES  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick_i,
    input  logic bfa_ok_i,
    input  logic mfas_hit_i,
    input  logic cfg_auto_resync_i,
    input  logic cfg_ais_off_i,
    output logic mf_loss_o,
    output logic mf_regained_o,
    output logic search_tmo_o,
    output logic resync_req_o,
    output logic ais_req_o,
    output logic mon_freeze_o
);
    mfa_regs_t r_d, r_q;

    logic w_load_long, w_load_short, w_clear, w_expire;
    logic s_restart, s_clear, s_pair_ok;

    e1_mfa_window #(
        .LONG_FRAMES (LONG_FRAMES),
        .SHORT_FRAMES(SHORT_FRAMES)
    ) i_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (frame_tick_i),
        .load_long_i (w_load_long),
        .load_short_i(w_load_short),
        .clear_i     (w_clear),
        .expire_o    (w_expire)
    );

    e1_mfa_spacing #(
        .LONG_FRAMES(LONG_FRAMES),
        .SPAN_FRAMES(SPAN_FRAMES)
    ) i_spacing (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (frame_tick_i),
        .restart_i (s_restart),
        .clear_i   (s_clear),
        .pair_ok_o (s_pair_ok)
    );

    always_comb begin
        r_d          = r_q;
        r_d.regained = 1'b0;
        r_d.tmo      = 1'b0;
        r_d.resync   = 1'b0;
        w_load_long  = 1'b0;
        w_load_short = 1'b0;
        w_clear      = 1'b0;
        s_restart    = 1'b0;
        s_clear      = 1'b0;
        if (!bfa_ok_i) begin
            r_d.state     = ST_LOST;
            r_d.mf_loss   = 1'b1;
            r_d.first_win = 1'b0;
            w_clear       = 1'b1;
            s_clear       = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_LOST: begin
                    r_d.state     = ST_HUNT;
                    r_d.first_win = 1'b1;
                    w_load_long   = 1'b1;
                    s_clear       = 1'b1;
                end
                ST_HUNT: begin
                    if (mfas_hit_i && s_pair_ok) begin
                        // Lock takes priority over a coincident expiry.
                        r_d.state    = ST_LOCKED;
                        r_d.mf_loss  = 1'b0;
                        r_d.regained = r_q.mf_loss;
                        w_clear      = 1'b1;
                        s_clear      = 1'b1;
                    end else if (mfas_hit_i) begin
                        s_restart    = 1'b1;
                        w_load_short = 1'b1;
                    end else if (w_expire) begin
                        r_d.tmo       = 1'b1;
                        r_d.resync    = cfg_auto_resync_i && r_q.first_win;
                        r_d.first_win = 1'b0;
                        w_load_long   = 1'b1;
                        s_clear       = 1'b1;
                    end
                end
                ST_LOCKED: begin
                end
                default: begin
                    r_d.state = ST_LOST;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_LOST, mf_loss: 1'b1, regained: 1'b0,
                     tmo: 1'b0, resync: 1'b0, first_win: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mf_loss_o     = r_q.mf_loss;
    assign mf_regained_o = r_q.regained;
    assign search_tmo_o  = r_q.tmo;
    assign resync_req_o  = r_q.resync;
    assign ais_req_o     = !bfa_ok_i && !cfg_ais_off_i;
    assign mon_freeze_o  = !bfa_ok_i;

    assert_loss_after_bfa_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bfa_ok_i |=> mf_loss_o);

    assert_regained_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mf_loss_o) |-> mf_regained_o);

    assert_regained_only_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mf_regained_o |-> (!mf_loss_o && $past(mf_loss_o)));

    assert_no_timeout_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_loss_o |-> !search_tmo_o);

    assert_resync_with_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req_o |-> search_tmo_o);

    assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mf_regained_o, search_tmo_o}));

endmodule

// File: tb/test_e1_mfa_ctrl.sv
module test_e1_mfa_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick_i = 1'b0;
    logic bfa_ok_i = 1'b0;
    logic mfas_hit_i = 1'b0;
    logic cfg_auto_resync_i = 1'b0;
    logic cfg_ais_off_i = 1'b0;
    logic mf_loss_o, mf_regained_o, search_tmo_o, resync_req_o, ais_req_o, mon_freeze_o;

    int n_checks = 0;
    int n_fail   = 0;
    int n_tmo = 0, n_reg = 0, n_rsy = 0;

    always #5 clk = ~clk;

    e1_mfa_ctrl i_e1_mfa_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .frame_tick_i     (frame_tick_i),
        .bfa_ok_i         (bfa_ok_i),
        .mfas_hit_i       (mfas_hit_i),
        .cfg_auto_resync_i(cfg_auto_resync_i),
        .cfg_ais_off_i    (cfg_ais_off_i),
        .mf_loss_o        (mf_loss_o),
        .mf_regained_o    (mf_regained_o),
        .search_tmo_o     (search_tmo_o),
        .resync_req_o     (resync_req_o),
        .ais_req_o        (ais_req_o),
        .mon_freeze_o     (mon_freeze_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (search_tmo_o)  n_tmo++;
            if (mf_regained_o) n_reg++;
            if (resync_req_o)  n_rsy++;
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock cycle with the given strobe and hit; returns just after the negedge.
    task automatic cyc(input logic t, input logic h);
        frame_tick_i = t;
        mfas_hit_i   = h;
        @(negedge clk);
        #1;
        frame_tick_i = 1'b0;
        mfas_hit_i   = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0);
            cyc(1'b0, 1'b0);
        end
    endtask

    task automatic drop_bfa();
        bfa_ok_i = 1'b0;
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
    endtask

    task automatic gain_bfa();
        bfa_ok_i = 1'b1;
        cyc(1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk(mf_loss_o, 1, "R1", "mf_loss after reset");
        chk(mf_regained_o, 0, "R1", "regained after reset");
        chk(search_tmo_o, 0, "R1", "timeout after reset");
        chk(resync_req_o, 0, "R1", "resync after reset");
        chk(ais_req_o, 1, "R8", "ais with bfa low");
        chk(mon_freeze_o, 1, "R8", "freeze with bfa low");
    endtask

    task automatic t_long_window();
        int t0;
        gain_bfa();
        chk(mon_freeze_o, 0, "R8", "freeze with bfa high");
        chk(ais_req_o, 0, "R8", "ais with bfa high");
        t0 = n_tmo;
        ticks(63);
        chk(n_tmo - t0, 0, "R4", "no timeout before strobe 64");
        ticks(1);
        chk(n_tmo - t0, 1, "R4", "timeout after strobe 64");
        ticks(64);
        chk(n_tmo - t0, 2, "R4", "repeat timeout");
        chk(n_rsy, 0, "R6", "no resync when disabled");
        drop_bfa();
    endtask

    task automatic t_lock_and_hold();
        int r0, t0;
        gain_bfa();
        r0 = n_reg;
        cyc(1'b0, 1'b1);
        ticks(16);
        chk(mf_loss_o, 1, "R2", "loss before second hit");
        cyc(1'b0, 1'b1);
        chk(mf_loss_o, 0, "R2", "loss cleared after pair");
        chk(mf_regained_o, 1, "R2", "regained pulse");
        cyc(1'b0, 1'b0);
        chk(mf_regained_o, 0, "R2", "regained one cycle only");
        chk(n_reg - r0, 1, "R2", "regained count");
        t0 = n_tmo;
        for (int i = 0; i < 10; i++) begin
            ticks(15);
            cyc(1'b0, 1'b1);
        end
        ticks(70);
        chk(mf_loss_o, 0, "R10", "stays locked");
        chk(n_tmo - t0, 0, "R10", "no timeout when locked");
        chk(n_reg - r0, 1, "R10", "no extra regained");
    endtask

    task automatic t_loss_clears();
        drop_bfa();
        chk(mf_loss_o, 1, "R7", "loss after bfa drop");
        cfg_ais_off_i = 1'b1;
        #1;
        chk(ais_req_o, 0, "R8", "ais suppressed");
        cfg_ais_off_i = 1'b0;
        cyc(1'b0, 1'b1);
        ticks(16);
        cyc(1'b0, 1'b1);
        chk(mf_loss_o, 1, "R7", "hits ignored while lost");
        gain_bfa();
        cyc(1'b0, 1'b1);
        ticks(8);
        drop_bfa();
        gain_bfa();
        ticks(8);
        cyc(1'b0, 1'b1);
        chk(mf_loss_o, 1, "R7", "pre-loss hit forgotten");
        drop_bfa();
    endtask

    task automatic t_bad_spacing();
        int t0;
        gain_bfa();
        t0 = n_tmo;
        cyc(1'b0, 1'b1);
        ticks(10);
        cyc(1'b0, 1'b1);
        chk(mf_loss_o, 1, "R3", "no lock at 10 strobes");
        ticks(47);
        chk(n_tmo - t0, 0, "R3", "window restarted from second hit");
        ticks(1);
        chk(n_tmo - t0, 1, "R3", "timeout 48 after restarted hit");
        drop_bfa();
        gain_bfa();
        cyc(1'b0, 1'b1);
        ticks(10);
        cyc(1'b0, 1'b1);
        ticks(32);
        cyc(1'b0, 1'b1);
        chk(mf_loss_o, 0, "R3", "lock counted from new first hit");
        drop_bfa();
    endtask

    task automatic t_short_window();
        int t0;
        gain_bfa();
        t0 = n_tmo;
        ticks(5);
        cyc(1'b0, 1'b1);
        ticks(47);
        chk(n_tmo - t0, 0, "R5", "no timeout before 48 after hit");
        ticks(1);
        chk(n_tmo - t0, 1, "R5", "timeout 48 after hit");
        drop_bfa();
    endtask

    task automatic t_auto_resync();
        int s0;
        cfg_auto_resync_i = 1'b1;
        gain_bfa();
        s0 = n_rsy;
        ticks(64);
        chk(n_rsy - s0, 1, "R6", "resync on first expiry");
        ticks(64);
        chk(n_rsy - s0, 1, "R6", "no resync on later expiry");
        cfg_auto_resync_i = 1'b0;
        drop_bfa();
    endtask

    task automatic t_coincident();
        int t0, r0;
        gain_bfa();
        t0 = n_tmo;
        r0 = n_reg;
        cyc(1'b0, 1'b1);
        ticks(47);
        cyc(1'b1, 1'b1);
        cyc(1'b0, 1'b0);
        chk(mf_loss_o, 0, "R9", "lock on coincident hit and expiry");
        chk(n_reg - r0, 1, "R9", "regained pulse");
        chk(n_tmo - t0, 0, "R9", "no timeout");
        drop_bfa();
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        cyc(1'b0, 1'b0);
        t_long_window();
        t_lock_and_hold();
        t_loss_clears();
        t_bad_spacing();
        t_short_window();
        t_auto_resync();
        t_coincident();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule